// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block holds the stores of an out-of-order core in program order, from the point where they are allocated until they are written to the data cache. Each store takes the next free slot together with a sequence tag that gives its age. The slot number goes back to the core, and the core later uses it to deliver the store's address and data. The two can arrive in either order. The core retires stores oldest first. Once a retired store at the head of the queue holds both its address and its data, it is offered to the cache. It moves only when the cache can take it and no load needs the cache port in that cycle.

Every load searches the queue. The newest value for its address may still be waiting here rather than in the cache. The load gives a word address and its own sequence tag. In a single combinational step, every live entry older than the load is compared against that address. The answer is one of three:
- forwarded data from the youngest older store that writes the same word;
- a miss, meaning the load should read the cache;
- wait, meaning the load must be replayed later.

A flush input discards every store that has not yet retired. Retired stores are kept, so that they still reach the cache.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: `allocReady` is 1, `allocIdx` is 0, `drainValid` is 0 and a load returns miss (`loadResult` = 2'b00).
- R2: With DEPTH (8) stores held, `allocReady` is 0 and an allocation request is ignored. Once one entry drains, exactly one more allocation fits.
- R3: A load returns miss (2'b00) when no live store older than it has a known address that equals the load address. Younger stores and stores to other addresses are ignored.
- R4: When one or more older stores match the load address and have their data, the load returns forward (2'b01). `loadData` then carries the data of the youngest of those stores.
- R5: When any live older store still lacks its address, the load returns wait (2'b10), whatever the other entries hold.
- R6: When the youngest older matching store has no data yet, the load returns wait (2'b10).
- R7: Address and data may be written in either order. A store is offered to the cache only when it holds both and has been retired.
- R8: Stores leave in allocation order, one per cycle, and only in a cycle where `cacheReady` is 1. While `drainValid` is 1, `drainAddr` and `drainData` show the oldest store.
- R9: A load in the same cycle whose result is miss takes the cache port. `drainValid` is then 0 and the head store stays in place. A load that is forwarded or told to wait does not block draining.
- R10: `flush` removes every store that has not retired, and the next allocation reuses the slot after the last retired store. Retired stores stay visible to loads and still drain. A retire or allocation requested in the flush cycle is ignored.
- R11: Ages are compared modulo 2^SEQ_W. A store is older than a load when (loadAge - storeSeq) mod 2^SEQ_W is nonzero and below 2^(SEQ_W-1), so tags that wrap past zero order correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Request to allocate a store slot |
| allocSeq | input | SEQ_W | Sequence tag of the allocating store |
| allocReady | output | 1 | A slot is free |
| allocIdx | output | log2(DEPTH) | Slot that an allocation in this cycle receives |
| addrValid | input | 1 | Store address write strobe |
| addrIdx | input | log2(DEPTH) | Slot receiving the address |
| addrIn | input | ADDR_W | Store word address |
| dataValid | input | 1 | Store data write strobe |
| dataIdx | input | log2(DEPTH) | Slot receiving the data |
| dataIn | input | DATA_W | Store data word |
| retireValid | input | 1 | Retire the oldest unretired store |
| flush | input | 1 | Discard all unretired stores |
| loadValid | input | 1 | A load is searching this cycle |
| loadAddr | input | ADDR_W | Load word address |
| loadAge | input | SEQ_W | Sequence tag of the load |
| loadResult | output | 2 | 00 miss, 01 forward, 10 wait |
| loadData | output | DATA_W | Forwarded data when result is forward |
| cacheReady | input | 1 | Cache can accept a store this cycle |
| drainValid | output | 1 | Head store is written to the cache this cycle |
| drainAddr | output | ADDR_W | Address of the draining store |
| drainData | output | DATA_W | Data of the draining store |

## Verification
The hardest case to reach is a queue that holds every kind of entry at once: stores with full contents, stores with data but no address, stores with an address but no data, and repeated addresses. Against such a queue, one load must differ from another only in its age. The bench builds that layout with separate address and data writes, then walks a table of loads whose ages cut the queue at different depths. Each cut exposes a different youngest match or an unresolved older entry. A second run after reset fills the queue with tags that wrap past zero. This exercises the modular age test and the full-queue case together.

// File: rtl/sq_pkg.sv
package sq_pkg;

  typedef enum logic [1:0] {
    LD_MISS = 2'b00,
    LD_FWD  = 2'b01,
    LD_WAIT = 2'b10
  } ld_res_e;

  // strobes from control to datapath
  typedef struct packed {
    logic allocEn;
    logic drainEn;
  } sq_strb_t;

endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             retireValid,
  input  logic             flush,
  input  logic             cacheReady,
  input  logic             loadPortBusy,
  input  logic             headComplete,
  output logic             allocReady,
  output logic             drainValid,
  output sq_strb_t         strb,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] retCnt;
  logic allocFire, retireFire, drainFire;

  assign allocReady = count < CNT_W'(DEPTH);
  assign allocFire  = allocValid && allocReady && !flush;
  assign retireFire = retireValid && (retCnt < count) && !flush;
  assign drainFire  = (retCnt != '0) && headComplete && cacheReady && !loadPortBusy;

  assign drainValid   = drainFire;
  assign strb.allocEn = allocFire;
  assign strb.drainEn = drainFire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head   <= '0;
      tail   <= '0;
      count  <= '0;
      retCnt <= '0;
    end else begin
      head   <= head + PTR_W'(drainFire);
      retCnt <= retCnt + CNT_W'(retireFire) - CNT_W'(drainFire);
      if (flush) begin
        // keep only the retired prefix
        tail  <= head + PTR_W'(retCnt);
        count <= retCnt - CNT_W'(drainFire);
      end else begin
        tail  <= tail + PTR_W'(allocFire);
        count <= count + CNT_W'(allocFire) - CNT_W'(drainFire);
      end
    end
  end

endmodule

// File: rtl/sq_data.sv
module sq_data
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEQ_W  = 6,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sq_strb_t          strb,
  input  logic [PTR_W-1:0]  head,
  input  logic [PTR_W-1:0]  tail,
  input  logic [CNT_W-1:0]  count,
  input  logic [SEQ_W-1:0]  allocSeq,
  input  logic              addrValid,
  input  logic [PTR_W-1:0]  addrIdx,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              dataValid,
  input  logic [PTR_W-1:0]  dataIdx,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [SEQ_W-1:0]  loadAge,
  output logic              headComplete,
  output logic [ADDR_W-1:0] drainAddr,
  output logic [DATA_W-1:0] drainData,
  output ld_res_e           loadResult,
  output logic [DATA_W-1:0] loadData
);

  logic [SEQ_W-1:0]  seqQ  [DEPTH];
  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic [DEPTH-1:0]  addrV, dataV;
  logic [DEPTH-1:0]  liveOld, addrHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrV <= '0;
      dataV <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        seqQ[i]  <= '0;
        addrQ[i] <= '0;
        dataQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strb.allocEn && tail == PTR_W'(i)) begin
          seqQ[i]  <= allocSeq;
          addrV[i] <= 1'b0;
          dataV[i] <= 1'b0;
        end else begin
          if (strb.drainEn && head == PTR_W'(i)) begin
            addrV[i] <= 1'b0;
            dataV[i] <= 1'b0;
          end
          if (addrValid && addrIdx == PTR_W'(i)) begin
            addrQ[i] <= addrIn;
            addrV[i] <= 1'b1;
          end
          if (dataValid && dataIdx == PTR_W'(i)) begin
            dataQ[i] <= dataIn;
            dataV[i] <= 1'b1;
          end
        end
      end
    end
  end

  // per-entry age and address compare, all in parallel
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [SEQ_W-1:0] ageDiff;
    logic [PTR_W-1:0] pos;
    assign ageDiff    = loadAge - seqQ[g];
    assign pos        = PTR_W'(g) - head;
    assign liveOld[g] = (CNT_W'(pos) < count) && (ageDiff != '0) && !ageDiff[SEQ_W-1];
    assign addrHit[g] = addrV[g] && (addrQ[g] == loadAddr);
  end

  logic             anyUnk, found;
  logic [PTR_W-1:0] sel, idx;

  // walk from oldest to youngest; the last hit is the youngest
  always_comb begin
    anyUnk = 1'b0;
    found  = 1'b0;
    sel    = '0;
    idx    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PTR_W'(k);
      if (liveOld[idx]) begin
        if (!addrV[idx]) begin
          anyUnk = 1'b1;
        end else if (addrHit[idx]) begin
          found = 1'b1;
          sel   = idx;
        end
      end
    end
  end

  always_comb begin
    if (anyUnk)                loadResult = LD_WAIT;
    else if (found && dataV[sel]) loadResult = LD_FWD;
    else if (found)            loadResult = LD_WAIT;
    else                       loadResult = LD_MISS;
  end

  assign loadData     = dataQ[sel];
  assign headComplete = addrV[head] && dataV[head];
  assign drainAddr    = addrQ[head];
  assign drainData    = dataQ[head];

endmodule

// File: rtl/store_queue.sv
module store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEQ_W  = 6,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [SEQ_W-1:0]  allocSeq,
  output logic              allocReady,
  output logic [PTR_W-1:0]  allocIdx,
  input  logic              addrValid,
  input  logic [PTR_W-1:0]  addrIdx,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              dataValid,
  input  logic [PTR_W-1:0]  dataIdx,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              retireValid,
  input  logic              flush,
  input  logic              loadValid,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [SEQ_W-1:0]  loadAge,
  output logic [1:0]        loadResult,
  output logic [DATA_W-1:0] loadData,
  input  logic              cacheReady,
  output logic              drainValid,
  output logic [ADDR_W-1:0] drainAddr,
  output logic [DATA_W-1:0] drainData
);

  sq_strb_t         strb;
  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             headComplete, loadPortBusy;
  ld_res_e          res;

  assign loadResult   = res;
  assign allocIdx     = tail;
  assign loadPortBusy = loadValid && (res == LD_MISS);

  sq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .allocValid   (allocValid),
    .retireValid  (retireValid),
    .flush        (flush),
    .cacheReady   (cacheReady),
    .loadPortBusy (loadPortBusy),
    .headComplete (headComplete),
    .allocReady   (allocReady),
    .drainValid   (drainValid),
    .strb         (strb),
    .head         (head),
    .tail         (tail),
    .count        (count)
  );

  sq_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .head         (head),
    .tail         (tail),
    .count        (count),
    .allocSeq     (allocSeq),
    .addrValid    (addrValid),
    .addrIdx      (addrIdx),
    .addrIn       (addrIn),
    .dataValid    (dataValid),
    .dataIdx      (dataIdx),
    .dataIn       (dataIn),
    .loadAddr     (loadAddr),
    .loadAge      (loadAge),
    .headComplete (headComplete),
    .drainAddr    (drainAddr),
    .drainData    (drainData),
    .loadResult   (res),
    .loadData     (loadData)
  );

endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadValid,
  input logic [1:0]       loadResult,
  input logic             drainValid,
  input logic             cacheReady,
  input logic             allocReady,
  input logic             flush,
  input logic [CNT_W-1:0] count
);

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    drainValid |-> !(loadValid && loadResult == 2'b00)); // R9

  AST_DRAIN_READY: assert property (@(posedge clk) disable iff (!rstN)
    drainValid |-> cacheReady); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (!allocReady && !drainValid && !flush) |=> !allocReady); // R2

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R2

  AST_RESULT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> loadResult != 2'b11); // R3

endmodule

bind store_queue sq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .loadValid  (loadValid),
  .loadResult (loadResult),
  .drainValid (drainValid),
  .cacheReady (cacheReady),
  .allocReady (allocReady),
  .flush      (flush),
  .count      (count)
);

// File: tb/store_queue_tb.sv
module store_queue_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        allocValid, allocReady;
  logic [5:0]  allocSeq;
  logic [2:0]  allocIdx;
  logic        addrValid, dataValid;
  logic [2:0]  addrIdx, dataIdx;
  logic [31:0] addrIn, dataIn;
  logic        retireValid, flush, loadValid, cacheReady;
  logic [31:0] loadAddr, loadData, drainAddr, drainData;
  logic [5:0]  loadAge;
  logic [1:0]  loadResult;
  logic        drainValid;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  store_queue u_dut (.*);

  typedef struct packed {
    logic [31:0] addr;
    logic [5:0]  age;
    logic [1:0]  res;
    logic [31:0] data;
  } vec_t;

  // queue: seq10 @100=A0, seq11 @104=B1, seq12 @100=C2, seq13 @108 no data, seq14 no addr
  localparam vec_t VECS [9] = '{
    '{32'h100, 6'd11, 2'b01, 32'hA0}, // R4 only one older match
    '{32'h100, 6'd13, 2'b01, 32'hC2}, // R4 youngest of two matches
    '{32'h104, 6'd13, 2'b01, 32'hB1}, // R4
    '{32'h200, 6'd13, 2'b00, 32'h0 }, // R3 no match
    '{32'h108, 6'd14, 2'b10, 32'h0 }, // R6 match without data
    '{32'h200, 6'd15, 2'b10, 32'h0 }, // R5 older unknown address
    '{32'h100, 6'd10, 2'b00, 32'h0 }, // R3 younger match ignored
    '{32'h100, 6'd15, 2'b10, 32'h0 }, // R5 unknown beats a match
    '{32'h104, 6'd12, 2'b01, 32'hB1}  // R4
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clkStep();
    @(posedge clk); #1;
  endtask

  task automatic doAlloc(input logic [5:0] s);
    allocValid = 1'b1; allocSeq = s; clkStep(); allocValid = 1'b0;
  endtask

  task automatic doAddr(input logic [2:0] i, input logic [31:0] a);
    addrValid = 1'b1; addrIdx = i; addrIn = a; clkStep(); addrValid = 1'b0;
  endtask

  task automatic doData(input logic [2:0] i, input logic [31:0] d);
    dataValid = 1'b1; dataIdx = i; dataIn = d; clkStep(); dataValid = 1'b0;
  endtask

  task automatic doRetire();
    retireValid = 1'b1; clkStep(); retireValid = 1'b0;
  endtask

  task automatic load(input logic [31:0] a, input logic [5:0] g);
    loadValid = 1'b1; loadAddr = a; loadAge = g; #2;
  endtask

  task automatic doReset();
    rstN = 1'b0; repeat (3) @(posedge clk); #1; rstN = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    allocValid = 0; allocSeq = 0; addrValid = 0; addrIdx = 0; addrIn = 0;
    dataValid = 0; dataIdx = 0; dataIn = 0; retireValid = 0; flush = 0;
    loadValid = 0; loadAddr = 0; loadAge = 0; cacheReady = 0;
    doReset();

    // R1 reset state
    cacheReady = 1'b1; load(32'h100, 6'd5);
    chk("R1 allocReady", allocReady, 1);
    chk("R1 allocIdx", allocIdx, 0);
    chk("R1 drainValid", drainValid, 0);
    chk("R1 loadResult", loadResult, 0);
    loadValid = 0; cacheReady = 0;

    // build the queue; R7 address and data in different orders
    for (int s = 10; s < 15; s++) doAlloc(6'(s));
    doAddr(0, 32'h100); doData(0, 32'hA0);
    doData(1, 32'hB1); doAddr(1, 32'h104);
    doAddr(2, 32'h100); doData(2, 32'hC2);
    doAddr(3, 32'h108);

    for (int v = 0; v < 9; v++) begin
      load(VECS[v].addr, VECS[v].age);
      chk(VECS[v].res == 2'b00 ? "R3 table result" :
          VECS[v].res == 2'b01 ? "R4 table result" : "R5 R6 table result",
          loadResult, VECS[v].res);
      if (VECS[v].res == 2'b01) chk("R4 table data", loadData, VECS[v].data);
      loadValid = 0;
    end

    // R7 data before address: still waiting
    doData(4, 32'hE4);
    load(32'h200, 6'd15); chk("R7 data only still waits", loadResult, 2'b10); loadValid = 0;
    doAddr(4, 32'h10C); doData(3, 32'hD3);
    load(32'h200, 6'd15); chk("R7 complete stores give miss", loadResult, 2'b00); loadValid = 0;
    load(32'h108, 6'd15); chk("R7 late data forwarded", loadData, 32'hD3); loadValid = 0;

    // R7 nothing drains before retirement
    cacheReady = 1'b1; #2; chk("R7 no drain unretired", drainValid, 0); cacheReady = 0;
    doRetire(); doRetire();
    #2; chk("R8 no drain without cacheReady", drainValid, 0);
    cacheReady = 1'b1;
    load(32'h200, 6'd15); chk("R9 miss load blocks drain", drainValid, 0);
    load(32'h100, 6'd15); chk("R9 forward load allows drain", drainValid, 1);
    loadValid = 0; #2;
    chk("R8 first drain addr", drainAddr, 32'h100);
    chk("R8 first drain data", drainData, 32'hA0);
    clkStep();
    chk("R8 second drain valid", drainValid, 1);
    chk("R8 second drain addr", drainAddr, 32'h104);
    chk("R8 second drain data", drainData, 32'hB1);
    clkStep();
    chk("R7 unretired head holds", drainValid, 0);
    cacheReady = 0;

    // R10 flush keeps the retired store
    doRetire();
    flush = 1'b1; clkStep(); flush = 1'b0;
    load(32'h108, 6'd20); chk("R10 flushed store gone", loadResult, 2'b00); loadValid = 0;
    load(32'h100, 6'd20); chk("R10 retired store kept", loadResult, 2'b01);
    chk("R10 retired store data", loadData, 32'hC2); loadValid = 0;
    chk("R10 next slot after retired", allocIdx, 3);
    cacheReady = 1'b1; #2;
    chk("R10 retired store drains", drainData, 32'hC2);
    clkStep(); chk("R10 empty after drain", drainValid, 0);
    cacheReady = 0;

    // second run: full queue, wrapping tags
    doReset();
    chk("R1 allocIdx after reset", allocIdx, 0);
    for (int s = 0; s < 8; s++) doAlloc(6'((60 + s) % 64));
    chk("R2 full deasserts ready", allocReady, 0);
    doAddr(0, 32'h500); doData(0, 32'h60);
    doAddr(1, 32'h500); doData(1, 32'h61);
    doAddr(2, 32'h400); doData(2, 32'h62);
    load(32'h400, 6'd63); chk("R11 wrap forward result", loadResult, 2'b01);
    chk("R11 wrap forward data", loadData, 32'h62); loadValid = 0;
    load(32'h500, 6'd63); chk("R4 youngest of wrapped", loadData, 32'h61); loadValid = 0;
    load(32'h400, 6'd0); chk("R11 seq63 older than 0", loadResult, 2'b10); loadValid = 0;
    doAlloc(6'd8); // ignored while full
    doRetire();
    cacheReady = 1'b1; #2;
    chk("R8 drain from full", drainAddr, 32'h500);
    clkStep(); cacheReady = 0;
    chk("R2 one slot free", allocReady, 1);
    chk("R2 wrapped slot", allocIdx, 0);
    doAlloc(6'd4);
    chk("R2 full again", allocReady, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule